// File: doc/BRIEF.md
# Timer-Referenced Output Compare Channel

This block is one output-compare channel. It watches the count of one of two free-running timers and drives one digital output pin. A select input picks which timer to watch. Compare events set, clear or toggle the pin, or form a pulse from two compare values. The channel can also generate a simple pulse-width-modulated waveform, with or without a shutdown input. Every compare event and every PWM period start raises a one-cycle interrupt flag.

A match event occurs in the first clock cycle in which the selected count equals a compare value. The count must have differed from that value in the cycle before, so a count held at a value for several cycles, as a prescaled timer does, produces one event. A period strobe counts only on the cycle it rises. All outputs are registered, so each one changes on the clock edge that samples the event that causes it. The mode field, the compare values and the select bit are plain level inputs, and a different value on the mode field counts as a new mode write.

Top module: `oc_channel`

## Requirements
- R1: Reset, or mode field value 000, drives `pin_out`, `pin_oe`, `evt_irq` and `fault_latched` low one edge later. It also clears all internal state: edge history, active duty, fault and done flags.
- R2: Mode 001 drives the pin high on a match event against `cmp_pri` and pulses `evt_irq`. Later events keep the pin high and pulse the flag again.
- R3: Entering mode 010 drives the pin high. A match event against `cmp_pri` then drives it low and pulses `evt_irq`. Entering any other non-zero mode drives the pin low and sets `pin_oe` high.
- R4: With `tsel` = 0 the channel uses `tmr_a_cnt` and `tmr_a_prd`. With `tsel` = 1 it uses `tmr_b_cnt` and `tmr_b_prd`, and matches on the other timer have no effect.
- R5: Mode 011 inverts the pin on every match event against `cmp_pri` and pulses `evt_irq` each time.
- R6: Mode 100 drives the pin high on a primary match event. A secondary (`cmp_sec`) match event that follows drives it low and pulses `evt_irq`. The channel then holds `pin_out` and `pin_oe` low and ignores matches until the mode field changes.
- R7: Mode 101 behaves like mode 100, with the irq pulse on each trailing edge, but it repeats indefinitely and keeps `pin_oe` high.
- R8: In modes 110 and 111, a period strobe event copies `cmp_sec` into the active duty value and pulses `evt_irq`. The same event drives the pin high, unless the incoming value is zero. A later match event between the count and the active duty drives the pin low. A change of `cmp_sec` within a period has no effect until the next strobe.
- R9: In PWM, a duty value of 0 keeps the pin low through the whole period. A duty value that the count never reaches keeps the pin high through the whole period.
- R10: In mode 111, a low level on `fault_n` drives the pin low and sets `fault_latched`. The pin then stays low across later periods, while `evt_irq` still pulses on each strobe. Only a change of the mode field clears `fault_latched`.
- R11: In mode 110 the `fault_n` input has no effect on the pin or on `fault_latched`.
- R12: `evt_irq` is never high in two consecutive cycles, and `pin_out` is never high while `pin_oe` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tmr_a_cnt | input | TW | Count of timer A |
| tmr_a_prd | input | 1 | Period strobe of timer A |
| tmr_b_cnt | input | TW | Count of timer B |
| tmr_b_prd | input | 1 | Period strobe of timer B |
| cmp_pri | input | TW | Primary compare value |
| cmp_sec | input | TW | Secondary compare value / PWM duty source |
| tsel | input | 1 | Timer select: 0 = A, 1 = B |
| mode | input | 3 | Operating mode (encoding in R1 to R11) |
| fault_n | input | 1 | Active-low fault input, used in mode 111 |
| pin_out | output | 1 | Output pin level |
| pin_oe | output | 1 | Output enable for the pin |
| evt_irq | output | 1 | One-cycle interrupt flag pulse |
| fault_latched | output | 1 | Latched fault status |

## Verification
The bench builds the channel with its default width TW = 16, so counts and compare values are the full 16 bits. The directed scenarios move the timer counts by hand, cycle by cycle. This lets each match edge, each strobe and each held count be placed exactly. Short PWM periods of eight counts are enough to cover duty reload, mid-period changes, zero duty and a duty beyond the period, along with fault entry and clearing.

// File: rtl/oc_pkg.sv
package oc_pkg;

  typedef enum logic [2:0] {
    OC_OFF  = 3'b000,
    OC_HIGH = 3'b001,
    OC_LOW  = 3'b010,
    OC_TOG  = 3'b011,
    OC_ONE  = 3'b100,
    OC_CONT = 3'b101,
    OC_PWM  = 3'b110,
    OC_PWMF = 3'b111
  } oc_mode_e;

  function automatic logic oc_is_pwm(input logic [2:0] m);
    return m[2] & m[1];
  endfunction

endpackage

// File: rtl/oc_tsel.sv
module oc_tsel #(
  parameter int TW = 16,
  parameter int NSRC = 2
) (
  input  logic          tsel,
  input  logic [TW-1:0] a_cnt,
  input  logic          a_prd,
  input  logic [TW-1:0] b_cnt,
  input  logic          b_prd,
  output logic [TW-1:0] cnt,
  output logic          prd
);

  logic [TW-1:0] cnt_v [NSRC];
  logic [NSRC-1:0] prd_v;

  assign cnt_v[0] = a_cnt;
  assign cnt_v[1] = b_cnt;
  assign prd_v    = {b_prd, a_prd};

  assign cnt = cnt_v[tsel];
  assign prd = prd_v[tsel];

endmodule

// File: rtl/oc_cmp.sv
module oc_cmp #(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          load_en,
  input  logic [TW-1:0] cnt,
  input  logic          prd,
  input  logic [TW-1:0] cmp_pri,
  input  logic [TW-1:0] cmp_sec,
  output logic          hit_pri,
  output logic          hit_sec,
  output logic          hit_duty,
  output logic          hit_prd,
  output logic          sec_nz
);

  localparam int NREF = 3;

  logic [TW-1:0]   duty_q;
  logic [TW-1:0]   refv [NREF];
  logic [NREF-1:0] hit;
  logic            prd_q;

  assign refv[0] = cmp_pri;
  assign refv[1] = cmp_sec;
  assign refv[2] = duty_q;

  // rising edge of equality per reference value
  for (genvar g = 0; g < NREF; g++) begin : g_ref
    logic eq;
    logic eq_q;
    assign eq = (cnt == refv[g]);
    always_ff @(posedge clk) begin
      if (rst || clr) eq_q <= 1'b0;
      else            eq_q <= eq;
    end
    assign hit[g] = eq & ~eq_q;
  end

  always_ff @(posedge clk) begin
    if (rst || clr) prd_q <= 1'b0;
    else            prd_q <= prd;
  end

  assign hit_prd  = prd & ~prd_q;
  assign hit_pri  = hit[0];
  assign hit_sec  = hit[1];
  assign hit_duty = hit[2];
  assign sec_nz   = |cmp_sec;

  // active duty shadow, reloaded only on a period event
  always_ff @(posedge clk) begin
    if (rst || clr)              duty_q <= '0;
    else if (load_en && hit_prd) duty_q <= cmp_sec;
  end

  a_r8_duty_reload: assert property (@(posedge clk) disable iff (rst)
    (!clr && load_en && hit_prd) |=> (duty_q == $past(cmp_sec)));

  a_r8_duty_held: assert property (@(posedge clk) disable iff (rst)
    (!clr && !hit_prd) |=> $stable(duty_q));

endmodule

// File: rtl/oc_ctrl.sv
module oc_ctrl
  import oc_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [2:0] mode,
  input  logic       hit_pri,
  input  logic       hit_sec,
  input  logic       hit_duty,
  input  logic       hit_prd,
  input  logic       sec_nz,
  input  logic       fault_n,
  output logic       pin_out,
  output logic       pin_oe,
  output logic       evt_irq,
  output logic       fault_latched
);

  oc_mode_e mode_in;
  oc_mode_e mode_q;
  logic     done_q;
  logic     wr;

  assign mode_in = oc_mode_e'(mode);
  assign wr      = (mode_in != mode_q);

  always_ff @(posedge clk) begin
    if (rst || mode_in == OC_OFF) begin
      mode_q        <= OC_OFF;
      pin_out       <= 1'b0;
      pin_oe        <= 1'b0;
      evt_irq       <= 1'b0;
      fault_latched <= 1'b0;
      done_q        <= 1'b0;
    end else if (wr) begin
      mode_q        <= mode_in;
      pin_out       <= (mode_in == OC_LOW);
      pin_oe        <= 1'b1;
      evt_irq       <= 1'b0;
      fault_latched <= 1'b0;
      done_q        <= 1'b0;
    end else begin
      evt_irq <= 1'b0;
      case (mode_q)
        OC_HIGH: if (hit_pri) begin
          pin_out <= 1'b1;
          evt_irq <= 1'b1;
        end
        OC_LOW: if (hit_pri) begin
          pin_out <= 1'b0;
          evt_irq <= 1'b1;
        end
        OC_TOG: if (hit_pri) begin
          pin_out <= ~pin_out;
          evt_irq <= 1'b1;
        end
        OC_ONE, OC_CONT: if (!done_q) begin
          if (pin_out && hit_sec) begin
            pin_out <= 1'b0;
            evt_irq <= 1'b1;
            if (mode_q == OC_ONE) begin
              done_q <= 1'b1;
              pin_oe <= 1'b0;
            end
          end else if (!pin_out && hit_pri) begin
            pin_out <= 1'b1;
          end
        end
        OC_PWM, OC_PWMF: begin
          evt_irq <= hit_prd;
          if (mode_q == OC_PWMF && (!fault_n || fault_latched)) begin
            pin_out       <= 1'b0;
            fault_latched <= 1'b1;
          end else if (hit_prd) begin
            pin_out <= sec_nz;
          end else if (hit_duty) begin
            pin_out <= 1'b0;
          end
        end
        default: ;
      endcase
    end
  end

  a_r1_off_quiet: assert property (@(posedge clk) disable iff (rst)
    (mode_in == OC_OFF) |=> (!pin_out && !pin_oe && !evt_irq && !fault_latched));

  a_r12_irq_one_cycle: assert property (@(posedge clk) disable iff (rst)
    evt_irq |=> !evt_irq);

  a_r12_pin_gated: assert property (@(posedge clk) disable iff (rst)
    !pin_oe |-> !pin_out);

  a_r10_fault_low: assert property (@(posedge clk) disable iff (rst)
    fault_latched |-> !pin_out);

  a_r10_fault_sticky: assert property (@(posedge clk) disable iff (rst)
    (fault_latched && mode_in == mode_q) |=> fault_latched);

  a_r5_toggle_flips: assert property (@(posedge clk) disable iff (rst)
    (mode_q == OC_TOG && mode_in == OC_TOG && hit_pri) |=> (pin_out != $past(pin_out)));

  a_r6_done_idle: assert property (@(posedge clk) disable iff (rst)
    done_q |-> (!pin_oe && !pin_out));

endmodule

// File: rtl/oc_channel.sv
module oc_channel
  import oc_pkg::*;
#(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [TW-1:0] tmr_a_cnt,
  input  logic          tmr_a_prd,
  input  logic [TW-1:0] tmr_b_cnt,
  input  logic          tmr_b_prd,
  input  logic [TW-1:0] cmp_pri,
  input  logic [TW-1:0] cmp_sec,
  input  logic          tsel,
  input  logic [2:0]    mode,
  input  logic          fault_n,
  output logic          pin_out,
  output logic          pin_oe,
  output logic          evt_irq,
  output logic          fault_latched
);

  logic [TW-1:0] cnt;
  logic          prd;
  logic          hit_pri, hit_sec, hit_duty, hit_prd, sec_nz;
  logic          clr;

  assign clr = (mode == OC_OFF);

  oc_tsel #(.TW(TW), .NSRC(2)) u_tsel (
    .tsel  (tsel),
    .a_cnt (tmr_a_cnt),
    .a_prd (tmr_a_prd),
    .b_cnt (tmr_b_cnt),
    .b_prd (tmr_b_prd),
    .cnt   (cnt),
    .prd   (prd)
  );

  oc_cmp #(.TW(TW)) u_cmp (
    .clk      (clk),
    .rst      (rst),
    .clr      (clr),
    .load_en  (oc_is_pwm(mode)),
    .cnt      (cnt),
    .prd      (prd),
    .cmp_pri  (cmp_pri),
    .cmp_sec  (cmp_sec),
    .hit_pri  (hit_pri),
    .hit_sec  (hit_sec),
    .hit_duty (hit_duty),
    .hit_prd  (hit_prd),
    .sec_nz   (sec_nz)
  );

  oc_ctrl u_ctrl (
    .clk           (clk),
    .rst           (rst),
    .mode          (mode),
    .hit_pri       (hit_pri),
    .hit_sec       (hit_sec),
    .hit_duty      (hit_duty),
    .hit_prd       (hit_prd),
    .sec_nz        (sec_nz),
    .fault_n       (fault_n),
    .pin_out       (pin_out),
    .pin_oe        (pin_oe),
    .evt_irq       (evt_irq),
    .fault_latched (fault_latched)
  );

endmodule

// File: tb/oc_channel_test.sv
module oc_channel_test;

  localparam int TW = 16;
  localparam int CLK_PERIOD = 10;
  localparam int WD_CYCLES = 20000;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [TW-1:0] tmr_a_cnt = '0;
  logic          tmr_a_prd = 1'b0;
  logic [TW-1:0] tmr_b_cnt = '0;
  logic          tmr_b_prd = 1'b0;
  logic [TW-1:0] cmp_pri = '0;
  logic [TW-1:0] cmp_sec = '0;
  logic          tsel = 1'b0;
  logic [2:0]    mode = 3'b000;
  logic          fault_n = 1'b1;
  logic          pin_out, pin_oe, evt_irq, fault_latched;

  int n_chk = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  oc_channel #(.TW(TW)) uut (
    .clk(clk), .rst(rst),
    .tmr_a_cnt(tmr_a_cnt), .tmr_a_prd(tmr_a_prd),
    .tmr_b_cnt(tmr_b_cnt), .tmr_b_prd(tmr_b_prd),
    .cmp_pri(cmp_pri), .cmp_sec(cmp_sec),
    .tsel(tsel), .mode(mode), .fault_n(fault_n),
    .pin_out(pin_out), .pin_oe(pin_oe), .evt_irq(evt_irq),
    .fault_latched(fault_latched)
  );

  // one clock edge passes; inputs are driven and outputs sampled at negedge
  task automatic cyc();
    @(negedge clk);
  endtask

  // expected vector order: {pin_out, pin_oe, evt_irq, fault_latched}
  task automatic expect4(input string req, input logic [3:0] exp);
    logic [3:0] act;
    act = {pin_out, pin_oe, evt_irq, fault_latched};
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: out/oe/irq/flt actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic go_mode(input logic [2:0] m);
    mode = m;
    cyc();
  endtask

  task automatic strobe_a(input logic [TW-1:0] c);
    tmr_a_cnt = c;
    tmr_a_prd = 1'b1;
    cyc();
    tmr_a_prd = 1'b0;
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) cyc();
    rst = 1'b0;
    cyc();
    expect4("R1 reset", 4'b0000);
  endtask

  task automatic t_high();
    go_mode(3'b000);
    tmr_a_cnt = 16'd5; cmp_pri = 16'd9;
    go_mode(3'b001);
    expect4("R3 entry 001", 4'b0100);
    tmr_a_cnt = 16'd9; cyc();
    expect4("R2 set on match", 4'b1110);
    cyc();
    expect4("R12 held count no second irq", 4'b1100);
    tmr_a_cnt = 16'd3; cyc();
    tmr_a_cnt = 16'd9; cyc();
    expect4("R2 repeat match", 4'b1110);
  endtask

  task automatic t_low();
    go_mode(3'b000);
    expect4("R1 off clears", 4'b0000);
    tmr_a_cnt = 16'd5;
    go_mode(3'b010);
    expect4("R3 entry 010 high", 4'b1100);
    tmr_a_cnt = 16'd9; cyc();
    expect4("R3 clear on match", 4'b0110);
  endtask

  task automatic t_tsel_toggle();
    go_mode(3'b000);
    tsel = 1'b1; tmr_a_cnt = 16'd5; tmr_b_cnt = 16'd3; cmp_pri = 16'hFFFF;
    go_mode(3'b011);
    tmr_a_cnt = 16'hFFFF; cyc();
    expect4("R4 other timer ignored", 4'b0100);
    tmr_b_cnt = 16'hFFFF; cyc();
    expect4("R5 toggle up via timer B", 4'b1110);
    tmr_b_cnt = 16'd2; cyc();
    expect4("R5 between matches", 4'b1100);
    tmr_b_cnt = 16'hFFFF; cyc();
    expect4("R5 toggle down", 4'b0110);
    tsel = 1'b0;
  endtask

  task automatic t_one_shot();
    go_mode(3'b000);
    tmr_a_cnt = 16'd0; cmp_pri = 16'd10; cmp_sec = 16'd20;
    go_mode(3'b100);
    tmr_a_cnt = 16'd10; cyc();
    expect4("R6 leading edge", 4'b1100);
    tmr_a_cnt = 16'd15; cyc();
    tmr_a_cnt = 16'd20; cyc();
    expect4("R6 trailing edge irq, disabled", 4'b0010);
    tmr_a_cnt = 16'd5; cyc();
    tmr_a_cnt = 16'd10; cyc();
    expect4("R6 later match ignored", 4'b0000);
  endtask

  task automatic t_cont();
    go_mode(3'b000);
    tmr_a_cnt = 16'd0;
    go_mode(3'b101);
    tmr_a_cnt = 16'd10; cyc();
    tmr_a_cnt = 16'd20; cyc();
    expect4("R7 trailing edge", 4'b0110);
    tmr_a_cnt = 16'd5; cyc();
    tmr_a_cnt = 16'd10; cyc();
    expect4("R7 repeats", 4'b1100);
  endtask

  task automatic t_pwm();
    go_mode(3'b000);
    tmr_a_cnt = 16'd5; cmp_sec = 16'd4;
    go_mode(3'b110);
    expect4("R8 before first strobe", 4'b0100);
    strobe_a(16'd7);
    expect4("R8 period start", 4'b1110);
    cmp_sec = 16'd6;
    for (int c = 0; c < 4; c++) begin
      tmr_a_cnt = TW'(c); cyc();
      expect4("R8 mid-period secondary change ignored", 4'b1100);
    end
    tmr_a_cnt = 16'd4; cyc();
    expect4("R8 duty match low", 4'b0100);
    tmr_a_cnt = 16'd5; cyc();
    strobe_a(16'd7);
    expect4("R8 second period start", 4'b1110);
    for (int c = 0; c < 6; c++) begin
      tmr_a_cnt = TW'(c); cyc();
    end
    expect4("R8 new duty still high at 5", 4'b1100);
    tmr_a_cnt = 16'd6; cyc();
    expect4("R8 reloaded duty low", 4'b0100);
    cmp_sec = 16'd0;
    strobe_a(16'd7);
    expect4("R9 zero duty low", 4'b0110);
    tmr_a_cnt = 16'd0; cyc();
    expect4("R9 zero duty stays low", 4'b0100);
    cmp_sec = 16'd9;
    strobe_a(16'd7);
    for (int c = 0; c < 7; c++) begin
      tmr_a_cnt = TW'(c); cyc();
    end
    expect4("R9 duty beyond period high", 4'b1100);
    strobe_a(16'd7);
    expect4("R9 high across period boundary", 4'b1110);
    go_mode(3'b000);
    expect4("R1 off from pwm", 4'b0000);
  endtask

  task automatic t_fault();
    tmr_a_cnt = 16'd5; cmp_sec = 16'd4; fault_n = 1'b1;
    go_mode(3'b111);
    strobe_a(16'd7);
    expect4("R10 pwm start", 4'b1110);
    tmr_a_cnt = 16'd1; cyc();
    fault_n = 1'b0; tmr_a_cnt = 16'd2; cyc();
    expect4("R10 fault forces low", 4'b0101);
    fault_n = 1'b1; tmr_a_cnt = 16'd3; cyc();
    expect4("R10 fault latched", 4'b0101);
    strobe_a(16'd7);
    expect4("R10 low across period, irq kept", 4'b0111);
    go_mode(3'b110);
    expect4("R10 mode rewrite clears", 4'b0100);
    go_mode(3'b111);
    strobe_a(16'd7);
    expect4("R10 pwm resumes", 4'b1110);
    go_mode(3'b110);
    strobe_a(16'd7);
    tmr_a_cnt = 16'd1; fault_n = 1'b0; cyc();
    expect4("R11 fault ignored in 110", 4'b1100);
    fault_n = 1'b1;
    go_mode(3'b000);
  endtask

  initial begin
    cyc();
    t_reset();
    t_high();
    t_low();
    t_tsel_toggle();
    t_one_shot();
    t_cont();
    t_pwm();
    t_fault();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog (R1..all): run did not end, actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule